// File: doc/BRIEF.md
# Multi-mode gated timer counter

This block is a 16-bit up/down timer counter driven by two asynchronous inputs: a count clock and a gate. Both inputs pass through a synchronizer and an edge detector on the system clock. Each one has its own polarity control, which selects its active edge or its active level. Software picks one of four modes, supplies an initial count and the delay and width lengths, and then pulses a start strobe. The start strobe latches all of these settings and restarts the mode from scratch.

Two modes count. Event counting advances on every active count-clock edge. Pulse-width measurement advances only while the gate is active, and it freezes when the gate goes inactive. Two modes generate pulses. Each waits for the first active gate edge, then times a delay and a high width in count-clock edges. One-shot mode does this once. Train mode repeats it indefinitely, using the delay as the low gap between pulses.

The running value is always present on the count output. Observing it has no side effect on counting.

Top module: `gated_timer`

## Requirements
- R1: While reset is asserted, and until the first start, count_out is 0 and pulse_out and done_out are 0.
- R2: In event mode (mode_sel 2'b00), start loads load_val into the count. Each later active count-clock edge then adds or subtracts one, wrapping modulo 2^16.
- R3: The count direction is up when the selected source is 1. The source is dir_pin when dir_from_pin is 1, and dir_up_sw otherwise. Both are sampled live.
- R4: In width mode (mode_sel 2'b01), after start the count advances only on active count-clock edges seen while the gate is at its active level. pulse_out stays 0 in both counting modes.
- R5: In width mode, the gate's active-to-inactive transition sets done_out and freezes the count. Further gate and clock activity has no effect until the next start.
- R6: In one-shot mode (mode_sel 2'b10), the first active gate edge after start arms a delay. After D active count-clock edges, pulse_out rises and stays high for W edges. It then falls and done_out rises. In this mode count_out shows the edges remaining in the current phase.
- R7: In one-shot mode, gate edges after the first one have no effect until the next start.
- R8: In train mode (mode_sel 2'b11), the first active gate edge starts a repeating pattern: D low edges, then W high edges, with D low edges again between pulses. done_out never rises in this mode.
- R9: An input change takes effect at the third rising edge of clk after it is applied. A polarity bit of 1 selects the rising edge and high level as active, and 0 selects the falling edge and low level.
- R10: A delay_val or width_val of 0 acts as 1 count-clock edge.
- R11: start clears pulse_out and done_out at the next clk edge and re-latches mode, load, delay and width. Changing mode_sel without a start has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_clk | input | 1 | Asynchronous count clock |
| tmr_gate | input | 1 | Asynchronous gate |
| clk_act_high | input | 1 | Count clock polarity (1 = rising edge is active) |
| gate_act_high | input | 1 | Gate polarity (1 = high level and rising edge are active) |
| dir_from_pin | input | 1 | Take the count direction from dir_pin instead of dir_up_sw |
| dir_pin | input | 1 | Hardware direction (1 = up) |
| dir_up_sw | input | 1 | Software direction (1 = up) |
| mode_sel | input | 2 | 00 event, 01 width, 10 one-shot, 11 train |
| start | input | 1 | One-cycle start strobe |
| load_val | input | 16 | Initial count for the counting modes |
| delay_val | input | 16 | Delay and gap length in count-clock edges |
| width_val | input | 16 | Pulse width in count-clock edges |
| count_out | output | 16 | Live count, or edges remaining in the current phase |
| pulse_out | output | 1 | Generated pulse |
| done_out | output | 1 | Measurement or one-shot finished |

## Verification
The assertions check the following on every cycle:
- A start always clears pulse_out and done_out.
- pulse_out and done_out are never high together.
- A raised done freezes the count.
- In the counting modes the count moves by at most one per cycle.
- Train mode never raises done, and pulses appear only in the pulse modes.

Only the bench's scenarios can show the exact values and timing: the three-edge input latency, polarity selection, wrap at 16 bits, the direction source, gate lock-out after the first trigger, zero lengths acting as one, and the number of pulses in a train.

// File: rtl/gt_pkg.sv
package gt_pkg;
   typedef enum logic [1:0] {
      MD_EVENT   = 2'b00,
      MD_WIDTH   = 2'b01,
      MD_ONESHOT = 2'b10,
      MD_TRAIN   = 2'b11
   } gt_mode_e;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_ARMED,
      PS_DELAY,
      PS_HIGH,
      PS_FINISHED
   } ps_state_e;
endpackage

// File: rtl/gt_sync.sv
module gt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic act_high,
   output logic lvl,
   output logic rise,
   output logic fall
);
   localparam int TOP = STAGES - 1;

   initial assert (STAGES >= 2) else $error("gt_sync: STAGES must be at least 2");

   logic [TOP:0] sh;
   logic         prev;
   logic         cur_act, prev_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[TOP-1:0], din};
         prev <= sh[TOP];
      end
   end

   always_comb begin
      cur_act  = act_high ? sh[TOP] : ~sh[TOP];
      prev_act = act_high ? prev    : ~prev;
      lvl      = cur_act;
      rise     = cur_act & ~prev_act;
      fall     = ~cur_act & prev_act;
   end
endmodule

// File: rtl/gt_event_cnt.sv
module gt_event_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         arm,
   input  logic         gated,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   input  logic         gate_lvl,
   input  logic         gate_fall,
   input  logic         up,
   output logic [W-1:0] cnt,
   output logic         done
);
   logic running, gated_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         gated_q <= 1'b0;
         done    <= 1'b0;
      end else if (start) begin
         running <= arm;
         gated_q <= gated;
         done    <= 1'b0;
         if (arm) cnt <= load_val;
      end else if (running) begin
         if (gated_q && gate_fall) begin
            running <= 1'b0;
            done    <= 1'b1;
         end else if (tick && (!gated_q || gate_lvl)) begin
            cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/gt_pulse_seq.sv
module gt_pulse_seq
   import gt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         arm,
   input  logic         cont,
   input  logic [W-1:0] delay_val,
   input  logic [W-1:0] width_val,
   input  logic         tick,
   input  logic         trig,
   output logic [W-1:0] ph,
   output logic         pulse,
   output logic         done
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   ps_state_e    state;
   logic         cont_q;
   logic [W-1:0] dly_q, wid_q;

   function automatic logic [W-1:0] at_least_one(input logic [W-1:0] v);
      return (v == '0) ? ONE : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PS_IDLE;
         ph     <= '0;
         pulse  <= 1'b0;
         done   <= 1'b0;
         cont_q <= 1'b0;
         dly_q  <= ONE;
         wid_q  <= ONE;
      end else if (start) begin
         state  <= arm ? PS_ARMED : PS_IDLE;
         ph     <= '0;
         pulse  <= 1'b0;
         done   <= 1'b0;
         cont_q <= cont;
         dly_q  <= at_least_one(delay_val);
         wid_q  <= at_least_one(width_val);
      end else begin
         case (state)
            PS_ARMED: if (trig) begin
               state <= PS_DELAY;
               ph    <= dly_q;
            end
            PS_DELAY: if (tick) begin
               if (ph == ONE) begin
                  state <= PS_HIGH;
                  pulse <= 1'b1;
                  ph    <= wid_q;
               end else begin
                  ph <= ph - 1'b1;
               end
            end
            PS_HIGH: if (tick) begin
               if (ph == ONE) begin
                  pulse <= 1'b0;
                  if (cont_q) begin
                     state <= PS_DELAY;
                     ph    <= dly_q;
                  end else begin
                     state <= PS_FINISHED;
                     ph    <= '0;
                     done  <= 1'b1;
                  end
               end else begin
                  ph <= ph - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
   import gt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_clk,
   input  logic             tmr_gate,
   input  logic             clk_act_high,
   input  logic             gate_act_high,
   input  logic             dir_from_pin,
   input  logic             dir_pin,
   input  logic             dir_up_sw,
   input  logic [1:0]       mode_sel,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] delay_val,
   input  logic [CNT_W-1:0] width_val,
   output logic [CNT_W-1:0] count_out,
   output logic             pulse_out,
   output logic             done_out
);
   initial assert (CNT_W >= 2) else $error("gated_timer: CNT_W must be at least 2");

   gt_mode_e         mode_q;
   logic             ck_rise, ck_lvl_unused, ck_fall_unused;
   logic             gt_lvl, gt_rise, gt_fall;
   logic             up;
   logic [CNT_W-1:0] ev_cnt, ph_cnt;
   logic             ev_done, ps_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= MD_EVENT;
      else if (start) mode_q <= gt_mode_e'(mode_sel);
   end

   gt_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
      .clk(clk), .rst_n(rst_n), .din(tmr_clk), .act_high(clk_act_high),
      .lvl(ck_lvl_unused), .rise(ck_rise), .fall(ck_fall_unused));

   gt_sync #(.STAGES(SYNC_STAGES)) u_gt_sync (
      .clk(clk), .rst_n(rst_n), .din(tmr_gate), .act_high(gate_act_high),
      .lvl(gt_lvl), .rise(gt_rise), .fall(gt_fall));

   assign up = dir_from_pin ? dir_pin : dir_up_sw;

   gt_event_cnt #(.W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .start(start), .arm(~mode_sel[1]),
      .gated(mode_sel[0]), .load_val(load_val), .tick(ck_rise),
      .gate_lvl(gt_lvl), .gate_fall(gt_fall), .up(up),
      .cnt(ev_cnt), .done(ev_done));

   gt_pulse_seq #(.W(CNT_W)) u_pseq (
      .clk(clk), .rst_n(rst_n), .start(start), .arm(mode_sel[1]),
      .cont(mode_sel[0]), .delay_val(delay_val), .width_val(width_val),
      .tick(ck_rise), .trig(gt_rise),
      .ph(ph_cnt), .pulse(pulse_out), .done(ps_done));

   always_comb begin
      count_out = mode_q[1] ? ph_cnt : ev_cnt;
      done_out  = ev_done | ps_done;
   end
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [1:0]   mode_q,
   input logic [W-1:0] count_out,
   input logic         pulse_out,
   input logic         done_out
);
   // R11
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done_out && !pulse_out));

   // R6
   pulse_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse_out && done_out));

   // R5
   done_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_out && !start) |=> (done_out && $stable(count_out)));

   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1] && !start) |=> (count_out == $past(count_out) ||
                                  count_out == $past(count_out) + W'(1) ||
                                  count_out == $past(count_out) - W'(1)));

   // R8
   train_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b11 && !start) |=> !done_out);

   // R4
   pulse_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_out |-> mode_q[1]);
endmodule

bind gated_timer gated_timer_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode_q(mode_q),
   .count_out(count_out), .pulse_out(pulse_out), .done_out(done_out));

// File: tb/sim_gated_timer.sv
`timescale 1ns/1ps
module sim_gated_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_clk = 1'b0, tmr_gate = 1'b0;
   logic        clk_act_high = 1'b1, gate_act_high = 1'b1;
   logic        dir_from_pin = 1'b0, dir_pin = 1'b0, dir_up_sw = 1'b1;
   logic [1:0]  mode_sel = 2'b00;
   logic        start = 1'b0;
   logic [15:0] load_val = '0, delay_val = '0, width_val = '0;
   logic [15:0] count_out;
   logic        pulse_out, done_out;

   int    n_checks = 0, n_fail = 0, rises = 0;
   bit    finished = 0, p_prev = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   gated_timer u0 (
      .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk), .tmr_gate(tmr_gate),
      .clk_act_high(clk_act_high), .gate_act_high(gate_act_high),
      .dir_from_pin(dir_from_pin), .dir_pin(dir_pin), .dir_up_sw(dir_up_sw),
      .mode_sel(mode_sel), .start(start), .load_val(load_val),
      .delay_val(delay_val), .width_val(width_val),
      .count_out(count_out), .pulse_out(pulse_out), .done_out(done_out));

   // Behavioural reference: inputs seen two samples late, edge against the sample before.
   bit ch[4], gh[4];
   int m_cnt, m_kind, m_dly, m_wid, m_mode;
   bit m_pulse, m_done, m_gated;

   always @(posedge clk) begin
      bit cl, cp, gl, gp, tick, grise, gfall, upd;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin ch[i] = 0; gh[i] = 0; end
         m_cnt = 0; m_kind = 0; m_pulse = 0; m_done = 0; m_gated = 0;
         m_dly = 1; m_wid = 1; m_mode = 0;
      end else begin
         for (int i = 3; i > 0; i--) begin ch[i] = ch[i-1]; gh[i] = gh[i-1]; end
         ch[0] = tmr_clk; gh[0] = tmr_gate;
         cl = clk_act_high ? ch[2] : !ch[2];
         cp = clk_act_high ? ch[3] : !ch[3];
         gl = gate_act_high ? gh[2] : !gh[2];
         gp = gate_act_high ? gh[3] : !gh[3];
         tick = cl && !cp; grise = gl && !gp; gfall = !gl && gp;
         upd = dir_from_pin ? dir_pin : dir_up_sw;
         if (start) begin
            m_mode = mode_sel; m_pulse = 0; m_done = 0;
            m_dly = (delay_val == 0) ? 1 : delay_val;
            m_wid = (width_val == 0) ? 1 : width_val;
            if (mode_sel < 2) begin
               m_cnt = load_val; m_kind = 1; m_gated = (mode_sel == 1);
            end else begin
               m_cnt = 0; m_kind = 3;
            end
         end else begin
            case (m_kind)
               1: if (m_gated && gfall) begin m_kind = 2; m_done = 1; end
                  else if (tick && (!m_gated || gl))
                     m_cnt = upd ? (m_cnt + 1) & 16'hFFFF : (m_cnt + 65535) & 16'hFFFF;
               3: if (grise) begin m_kind = 4; m_cnt = m_dly; end
               4: if (tick) begin
                     if (m_cnt == 1) begin m_kind = 5; m_pulse = 1; m_cnt = m_wid; end
                     else m_cnt--;
                  end
               5: if (tick) begin
                     if (m_cnt == 1) begin
                        m_pulse = 0;
                        if (m_mode == 3) begin m_kind = 4; m_cnt = m_dly; end
                        else begin m_kind = 6; m_cnt = 0; m_done = 1; end
                     end else m_cnt--;
                  end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         n_checks++;
         if (count_out !== 16'(m_cnt) || pulse_out !== m_pulse || done_out !== m_done) begin
            n_fail++;
            $display("FAIL %s cycle compare: actual cnt=%0d pulse=%0d done=%0d expected cnt=%0d pulse=%0d done=%0d",
                     cur_req, count_out, pulse_out, done_out, m_cnt, m_pulse, m_done);
         end
         if (pulse_out && !p_prev) rises++;
         p_prev = pulse_out;
      end
   end

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clk_pulses(int n);
      for (int i = 0; i < n; i++) begin
         tmr_clk = 1'b1; repeat (3) @(negedge clk);
         tmr_clk = 1'b0; repeat (3) @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic set_gate(bit v);
      tmr_gate = v; repeat (4) @(negedge clk);
   endtask

   task automatic do_start(int md, int ld, int dl, int wd);
      mode_sel = 2'(md); load_val = 16'(ld); delay_val = 16'(dl); width_val = 16'(wd);
      start = 1'b1; @(negedge clk);
      start = 1'b0; @(negedge clk);
   endtask

   task automatic report();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      cur_req = "R1";
      repeat (4) @(negedge clk);
      check("R1 count in reset", count_out, 0);
      check("R1 pulse in reset", pulse_out, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 done after reset", done_out, 0);

      cur_req = "R2";
      do_start(0, 10, 0, 0);
      check("R2 load", count_out, 10);
      clk_pulses(5);
      check("R2 up count", count_out, 15);
      cur_req = "R3";
      dir_up_sw = 1'b0;
      clk_pulses(3);
      check("R3 sw down", count_out, 12);
      dir_up_sw = 1'b1;
      cur_req = "R2";
      do_start(0, 16'hFFFE, 0, 0);
      clk_pulses(3);
      check("R2 wrap", count_out, 1);

      cur_req = "R3";
      dir_from_pin = 1'b1; dir_pin = 1'b0;
      do_start(0, 5, 0, 0);
      clk_pulses(2);
      check("R3 pin down", count_out, 3);
      dir_pin = 1'b1;
      clk_pulses(1);
      check("R3 pin up", count_out, 4);
      dir_from_pin = 1'b0;

      cur_req = "R9";
      do_start(0, 0, 0, 0);
      tmr_clk = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R9 not yet after two edges", count_out, 0);
      @(negedge clk);
      check("R9 counted on third edge", count_out, 1);
      tmr_clk = 1'b0; repeat (4) @(negedge clk);
      clk_act_high = 1'b0;
      do_start(0, 0, 0, 0);
      tmr_clk = 1'b1; repeat (4) @(negedge clk);
      check("R9 rising ignored when falling active", count_out, 0);
      tmr_clk = 1'b0; repeat (4) @(negedge clk);
      check("R9 falling counted", count_out, 1);
      clk_act_high = 1'b1; repeat (2) @(negedge clk);

      cur_req = "R4";
      do_start(1, 0, 0, 0);
      clk_pulses(3);
      check("R4 gate inactive", count_out, 0);
      set_gate(1);
      clk_pulses(4);
      check("R4 gate active", count_out, 4);
      check("R4 no pulse", pulse_out, 0);
      cur_req = "R5";
      set_gate(0);
      check("R5 done on gate fall", done_out, 1);
      set_gate(1);
      clk_pulses(2);
      set_gate(0);
      check("R5 count frozen", count_out, 4);
      check("R5 done held", done_out, 1);

      cur_req = "R6";
      do_start(2, 0, 2, 3);
      check("R11 done cleared", done_out, 0);
      clk_pulses(2);
      check("R6 no pulse before gate", pulse_out, 0);
      set_gate(1);
      clk_pulses(1);
      check("R6 delay remaining", count_out, 1);
      check("R6 low during delay", pulse_out, 0);
      clk_pulses(1);
      check("R6 pulse high", pulse_out, 1);
      clk_pulses(2);
      check("R6 still high", pulse_out, 1);
      clk_pulses(1);
      check("R6 pulse ended", pulse_out, 0);
      check("R6 done", done_out, 1);
      cur_req = "R7";
      set_gate(0); set_gate(1);
      clk_pulses(4);
      check("R7 retrigger ignored", pulse_out, 0);
      check("R7 done kept", done_out, 1);
      set_gate(0);

      cur_req = "R10";
      do_start(2, 0, 0, 0);
      set_gate(1);
      clk_pulses(1);
      check("R10 zero delay", pulse_out, 1);
      clk_pulses(1);
      check("R10 zero width", pulse_out, 0);
      check("R10 done", done_out, 1);
      set_gate(0);

      cur_req = "R8";
      do_start(3, 0, 1, 2);
      rises = 0;
      set_gate(1);
      clk_pulses(12);
      check("R8 pulses in train", rises, 4);
      check("R8 no done", done_out, 0);
      cur_req = "R11";
      mode_sel = 2'b00;
      clk_pulses(1);
      check("R11 mode change ignored", rises, 5);
      do_start(0, 7, 0, 0);
      check("R11 restart load", count_out, 7);
      check("R11 restart pulse", pulse_out, 0);
      clk_pulses(1);
      check("R11 new mode counts", count_out, 8);

      repeat (4) @(negedge clk);
      report();
   end
endmodule